// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block finds the most urgent pending interrupt for one processor target. A bank of sources is presented in parallel. For each source the block receives a pending-eligible bit, a routing-valid bit, an 8-bit priority, a non-maskable flag and a group bit. After a start strobe, the block reads one source per clock in rising ID order and keeps a running best candidate. When the scan ends, it can merge one external candidate, such as a message-signalled interrupt. The winner is then registered, and a one-cycle done pulse marks that it is ready.

A full scan clears the running best to the empty state first. A partial scan covers only an index window. It starts from the previously published winner and tracks whether any candidate displaced that winner. If no candidate did, and the old winner is valid and lies inside the window, the old winner may have lost its standing. The block then turns the work into a full scan from the empty state without any outside help.

Top module: `hps_sel`

## Requirements
- R1: A candidate whose effective priority value is strictly smaller than the running best's replaces it, so the smallest value wins.
- R2: When effective priorities are equal, a candidate with the non-maskable flag set beats one without it.
- R3: When effective priority and non-maskable flag are both equal, the candidate with the lower or equal ID wins, so the lowest ID among equals is published.
- R4: The effective priority of a non-maskable source is 0x80 when `sec_on` is 1 and the source's `src_nsgrp` bit is 1, and 0x00 in all other cases. A maskable source uses its own priority field, which is bits [8i+7:8i] of `src_prio` for source i.
- R5: The external candidate takes part in the final comparison only when `lpi_on`, `lpi_glob_on` and `g1ns_on` are all 1 and `ext_prio` is not 0xFF. It is then ranked by the same rules as R1 to R3.
- R6: Priority 0xFF means no interrupt: `hp_valid` is 0 exactly when `hp_prio` is 0xFF. A full scan starts from priority 0xFF, NMI flag 0 and ID 0, so a full scan with no eligible source publishes that value.
- R7: A source is eligible only when both its `src_pend` and `src_route` bits are 1. An ineligible source is never published.
- R8: `done` is a one-cycle pulse. For a scan of n sources that does not restart, `done` is high in the cycle after the (n+1)th rising edge following the edge that accepted `go`.
- R9: A partial scan over `rng_lo`..`rng_hi` (with `part_mode` = 1) starts from the published result. It keeps that result unless a candidate in the window outranks or equals it.
- R10: If no candidate in a partial window displaced the previous result, and that result is valid with its ID inside the window, the block rescans all NSRC sources from the empty state. The published result then equals that of a full scan, and the latency grows by NSRC cycles.
- R11: A `go` asserted while a scan is running is ignored. It changes neither the latency nor the result.
- R12: A synchronous `rst` clears the result to the no-interrupt value of R6. The result outputs change only with `done` or reset, and hold steady between scans even when inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start strobe, accepted only when idle |
| part_mode | input | 1 | 1 selects a partial scan over the index window |
| rng_lo | input | IDW | First source of the partial window |
| rng_hi | input | IDW | Last source of the partial window |
| src_pend | input | NSRC | Pending-eligible bit per source |
| src_route | input | NSRC | Routing names an implemented processor, per source |
| src_nmi | input | NSRC | Non-maskable flag per source |
| src_nsgrp | input | NSRC | Source belongs to the non-secure group |
| src_prio | input | NSRC*PW | Priority per source, source i at [PW*i +: PW] |
| sec_on | input | 1 | Security distinction enabled |
| lpi_on | input | 1 | Local enable for the external candidate |
| lpi_glob_on | input | 1 | Global enable for the external candidate |
| g1ns_on | input | 1 | Non-secure group 1 enable |
| ext_id | input | IDW | ID of the external candidate |
| ext_prio | input | PW | Priority of the external candidate |
| ext_nmi | input | 1 | Non-maskable flag of the external candidate |
| done | output | 1 | One-cycle pulse when the result is updated |
| hp_valid | output | 1 | Published result is a real interrupt |
| hp_id | output | IDW | Published winner ID |
| hp_prio | output | PW | Published winner effective priority |
| hp_nmi | output | 1 | Published winner non-maskable flag |

## Verification
The hardest case to reach from the ports is the self-triggered full rescan. It needs a partial window that holds the previous winner, with that winner no longer eligible or now worse, and no other source in the window able to replace it. The bench first publishes a known winner with a full scan. It then clears that winner's pending bit and places stronger candidates outside the window. A partial scan over the window must then come back with the outside candidate and the longer latency. Random partial scans over random windows check the same path, comparing against a rank-key model in the bench.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_FIN  = 2'd2
  } hps_state_t;

  // Ordering: smaller priority, then NMI set, then smaller or equal ID.
  function automatic logic outranks(
    input int unsigned cp, input logic cn, input int unsigned cid,
    input int unsigned bp, input logic bn, input int unsigned bid);
    if (cp != bp) return cp < bp;
    if (cn != bn) return cn;
    return cid <= bid;
  endfunction

endpackage

// File: rtl/hps_src_pick.sv
module hps_src_pick #(
  parameter int NSRC = 8,
  parameter int IDW  = 4,
  parameter int PW   = 8
) (
  input  logic [IDW-1:0]     idx,
  input  logic [NSRC-1:0]    src_pend,
  input  logic [NSRC-1:0]    src_route,
  input  logic [NSRC-1:0]    src_nmi,
  input  logic [NSRC-1:0]    src_nsgrp,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic               sec_on,
  output logic               c_ok,
  output logic               c_nmi,
  output logic [PW-1:0]      c_prio
);
  localparam logic [PW-1:0] HALF = {1'b1, {(PW-1){1'b0}}};

  function automatic logic [PW-1:0] eff_prio(
    input logic nmi, input logic sec, input logic ns, input logic [PW-1:0] raw);
    if (!nmi) return raw;
    return (sec && ns) ? HALF : '0;
  endfunction

  logic [PW-1:0]   eff [NSRC];
  logic [NSRC-1:0] ok;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign eff[g] = eff_prio(src_nmi[g], sec_on, src_nsgrp[g], src_prio[g*PW +: PW]);
    assign ok[g]  = src_pend[g] & src_route[g];
  end

  always_comb begin
    c_ok   = 1'b0;
    c_nmi  = 1'b0;
    c_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (idx == IDW'(i)) begin
        c_ok   = ok[i];
        c_nmi  = src_nmi[i];
        c_prio = eff[i];
      end
    end
  end

endmodule

// File: rtl/hps_rank.sv
module hps_rank #(
  parameter int IDW = 4,
  parameter int PW  = 8
) (
  input  logic [PW-1:0]  a_prio,
  input  logic           a_nmi,
  input  logic [IDW-1:0] a_id,
  input  logic [PW-1:0]  b_prio,
  input  logic           b_nmi,
  input  logic [IDW-1:0] b_id,
  output logic           a_wins
);
  assign a_wins = hps_pkg::outranks(32'(a_prio), a_nmi, 32'(a_id),
                                    32'(b_prio), b_nmi, 32'(b_id));
endmodule

// File: rtl/hps_sel.sv
module hps_sel #(
  parameter int NSRC = 8,
  parameter int IDW  = 4,
  parameter int PW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               part_mode,
  input  logic [IDW-1:0]     rng_lo,
  input  logic [IDW-1:0]     rng_hi,
  input  logic [NSRC-1:0]    src_pend,
  input  logic [NSRC-1:0]    src_route,
  input  logic [NSRC-1:0]    src_nmi,
  input  logic [NSRC-1:0]    src_nsgrp,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic               sec_on,
  input  logic               lpi_on,
  input  logic               lpi_glob_on,
  input  logic               g1ns_on,
  input  logic [IDW-1:0]     ext_id,
  input  logic [PW-1:0]      ext_prio,
  input  logic               ext_nmi,
  output logic               done,
  output logic               hp_valid,
  output logic [IDW-1:0]     hp_id,
  output logic [PW-1:0]      hp_prio,
  output logic               hp_nmi
);
  import hps_pkg::*;

  localparam logic [PW-1:0]  NONE    = '1;
  localparam logic [IDW-1:0] LAST_ID = IDW'(NSRC - 1);

  hps_state_t     st;
  logic [IDW-1:0] idx, lo_r, hi_r;
  logic           part_r, seen_r;
  logic [PW-1:0]  wk_prio;
  logic           wk_nmi;
  logic [IDW-1:0] wk_id;
  logic [PW-1:0]  res_prio;
  logic           res_nmi;
  logic [IDW-1:0] res_id;

  // Named events, also observed by the checker.
  logic busy, fin, load_best, last, take, restart, ext_ok, ext_take;
  logic c_ok, c_nmi, scan_win, ext_win;
  logic [PW-1:0] c_prio;

  hps_src_pick #(.NSRC(NSRC), .IDW(IDW), .PW(PW)) u_pick (
    .idx(idx), .src_pend(src_pend), .src_route(src_route), .src_nmi(src_nmi),
    .src_nsgrp(src_nsgrp), .src_prio(src_prio), .sec_on(sec_on),
    .c_ok(c_ok), .c_nmi(c_nmi), .c_prio(c_prio)
  );

  hps_rank #(.IDW(IDW), .PW(PW)) u_scan_rank (
    .a_prio(c_prio), .a_nmi(c_nmi), .a_id(idx),
    .b_prio(wk_prio), .b_nmi(wk_nmi), .b_id(wk_id),
    .a_wins(scan_win)
  );

  hps_rank #(.IDW(IDW), .PW(PW)) u_ext_rank (
    .a_prio(ext_prio), .a_nmi(ext_nmi), .a_id(ext_id),
    .b_prio(wk_prio), .b_nmi(wk_nmi), .b_id(wk_id),
    .a_wins(ext_win)
  );

  assign busy      = (st == S_SCAN);
  assign fin       = (st == S_FIN);
  assign load_best = (st == S_IDLE) && go;
  assign last      = busy && (idx == hi_r);
  assign take      = busy && c_ok && scan_win;
  assign restart   = last && part_r && !(seen_r || take) && (wk_prio != NONE)
                     && (wk_id >= lo_r) && (wk_id <= hi_r);
  assign ext_ok    = lpi_on && lpi_glob_on && g1ns_on && (ext_prio != NONE);
  assign ext_take  = fin && ext_ok && ext_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      lo_r     <= '0;
      hi_r     <= LAST_ID;
      part_r   <= 1'b0;
      seen_r   <= 1'b0;
      wk_prio  <= NONE;
      wk_nmi   <= 1'b0;
      wk_id    <= '0;
      res_prio <= NONE;
      res_nmi  <= 1'b0;
      res_id   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (go) begin
          st     <= S_SCAN;
          part_r <= part_mode;
          seen_r <= 1'b0;
          if (part_mode) begin
            idx     <= rng_lo;
            lo_r    <= rng_lo;
            hi_r    <= rng_hi;
            wk_prio <= res_prio;
            wk_nmi  <= res_nmi;
            wk_id   <= res_id;
          end else begin
            idx     <= '0;
            lo_r    <= '0;
            hi_r    <= LAST_ID;
            wk_prio <= NONE;
            wk_nmi  <= 1'b0;
            wk_id   <= '0;
          end
        end
        S_SCAN: begin
          if (take) begin
            wk_prio <= c_prio;
            wk_nmi  <= c_nmi;
            wk_id   <= idx;
          end
          seen_r <= seen_r | take;
          if (restart) begin
            idx     <= '0;
            lo_r    <= '0;
            hi_r    <= LAST_ID;
            part_r  <= 1'b0;
            seen_r  <= 1'b0;
            wk_prio <= NONE;
            wk_nmi  <= 1'b0;
            wk_id   <= '0;
          end else if (last) begin
            st <= S_FIN;
          end else begin
            idx <= idx + IDW'(1);
          end
        end
        S_FIN: begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (ext_take) begin
            res_prio <= ext_prio;
            res_nmi  <= ext_nmi;
            res_id   <= ext_id;
          end else begin
            res_prio <= wk_prio;
            res_nmi  <= wk_nmi;
            res_id   <= wk_id;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hp_prio  = res_prio;
  assign hp_nmi   = res_nmi;
  assign hp_id    = res_id;
  assign hp_valid = (res_prio != NONE);

endmodule

// File: rtl/hps_sel_chk.sv
module hps_sel_chk #(
  parameter int IDW = 4,
  parameter int PW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           go,
  input logic           done,
  input logic           busy,
  input logic           fin,
  input logic           last,
  input logic           restart,
  input logic           ext_take,
  input logic [IDW-1:0] idx,
  input logic [PW-1:0]  wk_prio,
  input logic [PW-1:0]  hp_prio,
  input logic [IDW-1:0] hp_id,
  input logic           hp_nmi
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_fin_then_done: assert property (@(posedge clk) disable iff (rst)
    fin |=> done);

  a_r1_best_never_worsens: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(restart)) |-> (wk_prio <= $past(wk_prio)));

  a_r10_restart_from_empty: assert property (@(posedge clk) disable iff (rst)
    restart |=> (busy && idx == '0 && wk_prio == '1));

  a_r11_go_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !last) |=> (busy && idx == IDW'($past(idx) + 1)));

  a_r12_result_held: assert property (@(posedge clk) disable iff (rst)
    !$stable({hp_prio, hp_id, hp_nmi}) |-> (done || $past(rst)));

  a_r5_ext_blocked: assert property (@(posedge clk) disable iff (rst)
    (fin && !ext_take) |=> (hp_prio == $past(wk_prio)));
endmodule

bind hps_sel hps_sel_chk #(.IDW(IDW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .go(go), .done(done), .busy(busy), .fin(fin),
  .last(last), .restart(restart), .ext_take(ext_take), .idx(idx),
  .wk_prio(wk_prio), .hp_prio(hp_prio), .hp_id(hp_id), .hp_nmi(hp_nmi)
);

// File: tb/hps_sel_test.sv
module hps_sel_test;
  localparam int NS = 8;
  localparam int IW = 4;
  localparam int PW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, go = 1'b0, part_mode = 1'b0;
  logic [IW-1:0] rng_lo = '0, rng_hi = '0, ext_id = '0;
  logic [NS-1:0] src_pend = '0, src_route = '0, src_nmi = '0, src_nsgrp = '0;
  logic [NS*PW-1:0] src_prio = '0;
  logic sec_on = 1'b0, lpi_on = 1'b0, lpi_glob_on = 1'b0, g1ns_on = 1'b0, ext_nmi = 1'b0;
  logic [PW-1:0] ext_prio = '1;
  logic done, hp_valid, hp_nmi;
  logic [IW-1:0] hp_id;
  logic [PW-1:0] hp_prio;

  hps_sel #(.NSRC(NS), .IDW(IW), .PW(PW)) uut (
    .clk(clk), .rst(rst), .go(go), .part_mode(part_mode), .rng_lo(rng_lo),
    .rng_hi(rng_hi), .src_pend(src_pend), .src_route(src_route),
    .src_nmi(src_nmi), .src_nsgrp(src_nsgrp), .src_prio(src_prio),
    .sec_on(sec_on), .lpi_on(lpi_on), .lpi_glob_on(lpi_glob_on),
    .g1ns_on(g1ns_on), .ext_id(ext_id), .ext_prio(ext_prio), .ext_nmi(ext_nmi),
    .done(done), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
    .hp_nmi(hp_nmi)
  );

  int total = 0, bad = 0;
  int e_prio = 255, e_nmi = 0, e_id = 0;
  int unsigned rs = 32'h1234_5678;

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Rank key: lexicographically smaller-or-equal key wins.
  function automatic int key(input int p, input int n, input int id);
    return (p << (IW + 1)) | ((n ? 0 : 1) << IW) | id;
  endfunction

  function automatic int eff(input int i);
    if (!src_nmi[i]) return int'(src_prio[i*PW +: PW]);
    return (sec_on && src_nsgrp[i]) ? 128 : 0;
  endfunction

  task automatic model(input bit part, input int lo, input int hi,
                       output int lat, output bit redo);
    int bp, bn, bi;
    bit seen;
    redo = 0; seen = 0;
    if (part) begin bp = e_prio; bn = e_nmi; bi = e_id; end
    else begin bp = 255; bn = 0; bi = 0; lo = 0; hi = NS - 1; end
    for (int i = lo; i <= hi; i++)
      if (src_pend[i] && src_route[i] && key(eff(i), src_nmi[i], i) <= key(bp, bn, bi)) begin
        bp = eff(i); bn = src_nmi[i]; bi = i; seen = 1;
      end
    lat = hi - lo + 2;
    if (part && !seen && bp != 255 && bi >= lo && bi <= hi) begin
      redo = 1; lat += NS; bp = 255; bn = 0; bi = 0;
      for (int i = 0; i < NS; i++)
        if (src_pend[i] && src_route[i] && key(eff(i), src_nmi[i], i) <= key(bp, bn, bi)) begin
          bp = eff(i); bn = src_nmi[i]; bi = i;
        end
    end
    if (lpi_on && lpi_glob_on && g1ns_on && ext_prio != 8'hFF &&
        key(int'(ext_prio), ext_nmi, int'(ext_id)) <= key(bp, bn, bi)) begin
      bp = int'(ext_prio); bn = ext_nmi; bi = int'(ext_id);
    end
    e_prio = bp; e_nmi = bn; e_id = bi;
  endtask

  task automatic check_res(input string tag);
    chk({tag, " valid"}, int'(hp_valid), int'(e_prio != 255));
    chk({tag, " id"}, int'(hp_id), e_id);
    chk({tag, " prio"}, int'(hp_prio), e_prio);
    chk({tag, " nmi"}, int'(hp_nmi), e_nmi);
  endtask

  task automatic run(input bit part, input int lo, input int hi,
                     input bit midgo, input string tag);
    int lat, cyc;
    bit redo;
    model(part, lo, hi, lat, redo);
    @(negedge clk);
    go = 1'b1; part_mode = part; rng_lo = IW'(lo); rng_hi = IW'(hi);
    @(negedge clk);
    go = 1'b0; cyc = 1;
    while (!done && cyc < 200) begin
      if (midgo && cyc == 3) begin go = 1'b1; part_mode = ~part; end
      else go = 1'b0;
      @(negedge clk);
      cyc++;
    end
    go = 1'b0;
    chk(redo ? "R10 latency" : (midgo ? "R11 latency" : "R8 latency"), cyc - 1, lat);
    check_res(tag);
  endtask

  task automatic set_prio(input int i, input int p);
    src_prio[i*PW +: PW] = PW'(p);
  endtask

  task automatic clear_src();
    src_pend = '0; src_route = '1; src_nmi = '0; src_nsgrp = '0; src_prio = '0;
    sec_on = 0; lpi_on = 0; lpi_glob_on = 0; g1ns_on = 0; ext_prio = '1; ext_nmi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_src();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12/R6: reset state
    chk("R12 reset done", int'(done), 0);
    check_res("R12 reset");

    // R6: empty full scan
    run(0, 0, 0, 0, "R6 empty");

    // R1: distinct priorities, minimum at each index
    for (int m = 0; m < NS; m++) begin
      clear_src(); src_pend = '1;
      for (int i = 0; i < NS; i++) set_prio(i, 16 + 8 * ((i + NS - m) % NS));
      run(0, 0, 0, 0, "R1 min prio");
      chk("R1 winner", int'(hp_id), m);
    end
    // R6: full scan after a valid result resets the best
    clear_src();
    run(0, 0, 0, 0, "R6 reset best");

    // R2/R4: equal 0x80 effective priority, NMI wins at any index
    for (int m = 0; m < NS; m++) begin
      clear_src(); src_pend = '1; sec_on = 1; src_nsgrp = '1;
      for (int i = 0; i < NS; i++) set_prio(i, 128);
      src_nmi[m] = 1'b1; set_prio(m, 7);
      run(0, 0, 0, 0, "R2 nmi tie");
      chk("R2 winner", int'(hp_id), m);
    end

    // R3: exhaustive pending masks, all equal priority
    for (int mask = 0; mask < (1 << NS); mask++) begin
      clear_src(); src_pend = NS'(mask);
      for (int i = 0; i < NS; i++) set_prio(i, 64);
      run(0, 0, 0, 0, "R3 lowest id");
    end

    // R4: NMI substitution for every security/group combination
    for (int c = 0; c < 4; c++) begin
      clear_src(); src_pend[5] = 1; src_nmi[5] = 1; set_prio(5, 48);
      sec_on = c[0]; src_nsgrp[5] = c[1];
      run(0, 0, 0, 0, "R4 nmi prio");
      chk("R4 value", int'(hp_prio), (c == 3) ? 128 : 0);
    end

    // R7: best source not routed, or not pending
    for (int m = 0; m < NS; m++) begin
      clear_src(); src_pend = '1;
      for (int i = 0; i < NS; i++) set_prio(i, 100 + i);
      set_prio(m, 1); src_route[m] = 1'b0;
      run(0, 0, 0, 0, "R7 unrouted");
      chk("R7 not chosen", int'(hp_id == IW'(m)), 0);
    end

    // R5: external gating, every enable combination, with 0xFF and real priority
    for (int c = 0; c < 16; c++) begin
      clear_src(); src_pend[2] = 1; set_prio(2, 60);
      lpi_on = c[0]; lpi_glob_on = c[1]; g1ns_on = c[2];
      ext_prio = c[3] ? 8'hFF : 8'd20; ext_id = 4'd12;
      run(0, 0, 0, 0, "R5 ext gate");
      chk("R5 ext chosen", int'(hp_id == 4'd12), int'(c == 7));
    end

    // R9: partial window not holding winner keeps it
    clear_src(); src_pend = 8'b0000_1001; set_prio(0, 30); set_prio(3, 40);
    run(0, 0, 0, 0, "R9 setup");
    src_pend[0] = 0;
    run(1, 2, 5, 0, "R9 keep");
    chk("R9 kept id", int'(hp_id), 0);

    // R10: winner dropped inside window, stronger source outside
    clear_src(); src_pend = 8'b1000_0100; set_prio(2, 30); set_prio(7, 90);
    run(0, 0, 0, 0, "R10 setup");
    src_pend[2] = 0; src_pend[6] = 1; set_prio(6, 10);
    run(1, 1, 3, 0, "R10 restart");
    chk("R10 outside winner", int'(hp_id), 6);

    // R11: go during a running scan
    clear_src(); src_pend = 8'b0110_0000; set_prio(5, 9); set_prio(6, 3);
    run(0, 0, 0, 1, "R11 midgo");

    // Random mix of full and partial scans
    for (int t = 0; t < 400; t++) begin
      int lo, hi;
      src_pend = NS'(rnd()); src_route = NS'(rnd() | rnd());
      src_nmi = NS'(rnd() & rnd()); src_nsgrp = NS'(rnd());
      for (int i = 0; i < NS; i++) set_prio(i, (rnd() % 4 == 0) ? 255 : int'(rnd() % 8) * 32);
      sec_on = rnd() % 2; lpi_on = (rnd() % 4) != 0; lpi_glob_on = (rnd() % 4) != 0;
      g1ns_on = (rnd() % 4) != 0; ext_nmi = rnd() % 2;
      ext_prio = (rnd() % 3 == 0) ? 8'hFF : PW'((rnd() % 8) * 32);
      ext_id = IW'(8 + rnd() % 8);
      lo = int'(rnd() % NS); hi = lo + int'(rnd() % (NS - lo));
      run(rnd() % 2, lo, hi, 0, (t % 2) ? "R9 random" : "R10 random");
    end

    // R12: result held while inputs change, then reset clears it
    clear_src(); src_pend[4] = 1; set_prio(4, 22);
    run(0, 0, 0, 0, "R12 setup");
    src_pend = '1; src_prio = '0;
    repeat (6) @(negedge clk);
    check_res("R12 hold");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e_prio = 255; e_nmi = 0; e_id = 0;
    @(negedge clk);
    check_res("R12 clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule